// File: doc/BRIEF.md
# Predicated Integer ALU

This block performs one integer data-processing operation per clock cycle. It takes a first operand and a second operand that has already passed through an external shifter. It also takes the shifter's carry-out and the current N, Z, C and V condition flags. Before any state changes, a 4-bit condition field is tested against the incoming flags. If the test fails, the operation still computes a value, but nothing is written back.

The operation set covers six arithmetic forms: plain and reverse subtracts, each with or without the incoming carry, and add with or without carry. It also covers four test forms that only set flags and seven bitwise and move forms. The block registers all outputs once. A caller presents an operation in one cycle and reads the value, the destination write enable, the new flags and the flag write enable after the next rising edge. When no flag update happens, the flag output simply carries the incoming flags through. When no result write happens, the result output keeps its last written value.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the first operation is accepted two cycles after the reset pin rises.

Top module: `cond_alu`

## Requirements
- R1: The condition field `cond_i` passes as follows: 0000 Z=1, 0001 Z=0, 0010 C=1, 0011 C=0, 0100 N=1, 0101 N=0, 0110 V=1, 0111 V=0, 1000 C=1 and Z=0, 1001 C=0 or Z=1, 1010 N=V, 1011 N!=V, 1100 Z=0 and N=V, 1101 Z=1 or N!=V, 1110 always. 1111 never passes.
- R2: When the condition fails, `result_we_o` and `flags_we_o` are 0 after the next edge. In that case `result_o` holds its previous value and `flags_o` equals the `flags_i` that was presented.
- R3: Arithmetic opcodes (`op_i`) compute: 2 SUB a-b, 3 RSB b-a, 4 ADD a+b, 5 ADC a+b+C, 6 SBC a-b+C-1, 7 RSC b-a+C-1. The value is taken modulo 2^32.
- R4: Test opcodes 8 TST (a AND b), 9 TEQ (a XOR b), 10 CMP (a-b) and 11 CMN (a+b) never write a result. When their condition passes, they update the flags whether or not `set_flags_i` is set.
- R5: Bitwise and move opcodes compute: 0 AND, 1 EOR, 12 ORR, 16 ORN (a OR NOT b), 14 BIC (a AND NOT b), 13 MOV (b) and 15 MVN (NOT b). MOV and MVN do not depend on a.
- R6: Opcodes other than the tests update the flags only when `set_flags_i` is 1 and the condition passes. They write the result whenever the condition passes.
- R7: The flag vector is ordered {N,Z,C,V} (bit 3 down to 0). When flags update, N is bit 31 of the computed value and Z is 1 exactly when the value is zero.
- R8: For arithmetic and CMP/CMN, C is the carry out of bit 31. For subtracts this means 1 when no borrow occurs. V is 1 on signed two's-complement overflow.
- R9: For bitwise, move, TST and TEQ operations, C takes `shift_carry_i` and V keeps the value in `flags_i`.
- R10: All outputs are registered with a latency of one edge. While reset is asserted, all outputs are zero.
- R11: Opcodes 17 to 31 write neither the result nor the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 5 | Operation code |
| cond_i | input | 4 | Condition field |
| set_flags_i | input | 1 | Request flag update for non-test operations |
| op_a_i | input | 32 | First operand |
| op_b_i | input | 32 | Shifted second operand |
| flags_i | input | 4 | Current {N,Z,C,V} |
| shift_carry_i | input | 1 | Carry-out of the external shifter |
| result_o | output | 32 | Last written result |
| result_we_o | output | 1 | Result write enable |
| flags_o | output | 4 | New {N,Z,C,V} |
| flags_we_o | output | 1 | Flag write enable |

## Verification
Every internal path ends in a register one edge away from the ports, so a wrong decode, condition or flag rule shows up on the very next cycle. It appears as a wrong enable pair, a flag vector that differs from the incoming one when no update was due, or a result that changes when no write was due. A wrong carry-in or operand swap in the adder shows up only on the value and the C or V flag of the affected opcode. For that reason, boundary operands such as 0x7FFFFFFF+1, equal operands and 0-1 are driven as directed cases next to the random stream.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  localparam int OP_W   = 5;
  localparam int COND_W = 4;
  localparam int FLAG_W = 4;

  // flag vector bit positions
  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;

  typedef enum logic [OP_W-1:0] {
    OP_AND = 5'd0,
    OP_EOR = 5'd1,
    OP_SUB = 5'd2,
    OP_RSB = 5'd3,
    OP_ADD = 5'd4,
    OP_ADC = 5'd5,
    OP_SBC = 5'd6,
    OP_RSC = 5'd7,
    OP_TST = 5'd8,
    OP_TEQ = 5'd9,
    OP_CMP = 5'd10,
    OP_CMN = 5'd11,
    OP_ORR = 5'd12,
    OP_MOV = 5'd13,
    OP_BIC = 5'd14,
    OP_MVN = 5'd15,
    OP_ORN = 5'd16
  } alu_op_e;

  typedef enum logic [COND_W-1:0] {
    CC_EQ = 4'd0,  CC_NE = 4'd1,  CC_CS = 4'd2,  CC_CC = 4'd3,
    CC_MI = 4'd4,  CC_PL = 4'd5,  CC_VS = 4'd6,  CC_VC = 4'd7,
    CC_HI = 4'd8,  CC_LS = 4'd9,  CC_GE = 4'd10, CC_LT = 4'd11,
    CC_GT = 4'd12, CC_LE = 4'd13, CC_AL = 4'd14, CC_NV = 4'd15
  } cond_e;

  typedef enum logic [1:0] {
    CLS_NONE  = 2'd0,
    CLS_ARITH = 2'd1,
    CLS_LOGIC = 2'd2
  } op_cls_e;

  typedef struct packed {
    op_cls_e cls;
    logic    test_only;
    logic    known;
  } op_dec_t;

  function automatic op_dec_t decode_op(input logic [OP_W-1:0] op);
    op_dec_t d;
    d.cls       = CLS_NONE;
    d.test_only = 1'b0;
    d.known     = 1'b1;
    case (op)
      OP_SUB, OP_RSB, OP_ADD, OP_ADC,
      OP_SBC, OP_RSC:                  d.cls = CLS_ARITH;
      OP_CMP, OP_CMN: begin
        d.cls       = CLS_ARITH;
        d.test_only = 1'b1;
      end
      OP_TST, OP_TEQ: begin
        d.cls       = CLS_LOGIC;
        d.test_only = 1'b1;
      end
      OP_AND, OP_EOR, OP_ORR, OP_MOV,
      OP_BIC, OP_MVN, OP_ORN:          d.cls = CLS_LOGIC;
      default:                         d.known = 1'b0;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/cond_alu_rst_sync.sv
module cond_alu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/cond_alu_cond.sv
module cond_alu_cond
  import cond_alu_pkg::*;
(
  input  logic [COND_W-1:0] cond,
  input  logic [FLAG_W-1:0] nzcv,
  output logic              pass
);

  logic n, z, c, v;

  always_comb begin
    n = nzcv[FL_N];
    z = nzcv[FL_Z];
    c = nzcv[FL_C];
    v = nzcv[FL_V];
    case (cond_e'(cond))
      CC_EQ:   pass = z;
      CC_NE:   pass = !z;
      CC_CS:   pass = c;
      CC_CC:   pass = !c;
      CC_MI:   pass = n;
      CC_PL:   pass = !n;
      CC_VS:   pass = v;
      CC_VC:   pass = !v;
      CC_HI:   pass = c && !z;
      CC_LS:   pass = !c || z;
      CC_GE:   pass = (n == v);
      CC_LT:   pass = (n != v);
      CC_GT:   pass = !z && (n == v);
      CC_LE:   pass = z || (n != v);
      CC_AL:   pass = 1'b1;
      default: pass = 1'b0;
    endcase
  end

endmodule

// File: rtl/cond_alu_arith.sv
module cond_alu_arith
  import cond_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  input  logic            carry_flag,
  output logic [W-1:0]    sum,
  output logic            carry_out,
  output logic            overflow
);

  logic [W-1:0] x, y;
  logic         cin;
  logic [W:0]   wide;

  // every form reduces to x + y + cin
  always_comb begin
    x   = a;
    y   = b;
    cin = 1'b0;
    case (alu_op_e'(op))
      OP_ADD, OP_CMN: begin x = a; y = b;  cin = 1'b0;       end
      OP_ADC:         begin x = a; y = b;  cin = carry_flag; end
      OP_SUB, OP_CMP: begin x = a; y = ~b; cin = 1'b1;       end
      OP_SBC:         begin x = a; y = ~b; cin = carry_flag; end
      OP_RSB:         begin x = b; y = ~a; cin = 1'b1;       end
      OP_RSC:         begin x = b; y = ~a; cin = carry_flag; end
      default:        begin x = a; y = b;  cin = 1'b0;       end
    endcase
    wide      = {1'b0, x} + {1'b0, y} + {{W{1'b0}}, cin};
    sum       = wide[W-1:0];
    carry_out = wide[W];
    overflow  = (x[W-1] == y[W-1]) && (wide[W-1] != x[W-1]);
  end

endmodule

// File: rtl/cond_alu_logic.sv
module cond_alu_logic
  import cond_alu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [OP_W-1:0] op,
  input  logic [W-1:0]    a,
  input  logic [W-1:0]    b,
  output logic [W-1:0]    value
);

  always_comb begin
    case (alu_op_e'(op))
      OP_AND, OP_TST: value = a & b;
      OP_EOR, OP_TEQ: value = a ^ b;
      OP_ORR:         value = a | b;
      OP_ORN:         value = a | ~b;
      OP_BIC:         value = a & ~b;
      OP_MOV:         value = b;
      OP_MVN:         value = ~b;
      default:        value = '0;
    endcase
  end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int W          = 32,
  parameter int SYNC_STAGE = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OP_W-1:0]   op_i,
  input  logic [COND_W-1:0] cond_i,
  input  logic              set_flags_i,
  input  logic [W-1:0]      op_a_i,
  input  logic [W-1:0]      op_b_i,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              shift_carry_i,
  output logic [W-1:0]      result_o,
  output logic              result_we_o,
  output logic [FLAG_W-1:0] flags_o,
  output logic              flags_we_o
);

  logic              rst_n_s;
  logic              cond_pass;
  op_dec_t           dec;
  logic [W-1:0]      arith_val, logic_val, value;
  logic              arith_c, arith_v;
  logic              res_we_d, flag_we_d;
  logic [FLAG_W-1:0] nzcv_new, flags_d;
  logic [W-1:0]      result_d;

  logic [W-1:0]      result_q;
  logic              res_we_q, flag_we_q;
  logic [FLAG_W-1:0] flags_q;

  cond_alu_rst_sync #(.STAGES(SYNC_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  cond_alu_cond u_cond (
    .cond (cond_i),
    .nzcv (flags_i),
    .pass (cond_pass)
  );

  cond_alu_arith #(.W(W)) u_arith (
    .op         (op_i),
    .a          (op_a_i),
    .b          (op_b_i),
    .carry_flag (flags_i[FL_C]),
    .sum        (arith_val),
    .carry_out  (arith_c),
    .overflow   (arith_v)
  );

  cond_alu_logic #(.W(W)) u_logic (
    .op    (op_i),
    .a     (op_a_i),
    .b     (op_b_i),
    .value (logic_val)
  );

  // next-state
  always_comb begin
    dec       = decode_op(op_i);
    value     = (dec.cls == CLS_ARITH) ? arith_val : logic_val;
    res_we_d  = cond_pass && dec.known && !dec.test_only;
    flag_we_d = cond_pass && dec.known && (dec.test_only || set_flags_i);

    nzcv_new       = flags_i;
    nzcv_new[FL_N] = value[W-1];
    nzcv_new[FL_Z] = (value == '0);
    if (dec.cls == CLS_ARITH) begin
      nzcv_new[FL_C] = arith_c;
      nzcv_new[FL_V] = arith_v;
    end else begin
      nzcv_new[FL_C] = shift_carry_i;
    end

    flags_d  = flag_we_d ? nzcv_new : flags_i;
    result_d = res_we_d ? value : result_q;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      result_q  <= '0;
      res_we_q  <= 1'b0;
      flags_q   <= '0;
      flag_we_q <= 1'b0;
    end else begin
      result_q  <= result_d;
      res_we_q  <= res_we_d;
      flags_q   <= flags_d;
      flag_we_q <= flag_we_d;
    end
  end

  assign result_o    = result_q;
  assign result_we_o = res_we_q;
  assign flags_o     = flags_q;
  assign flags_we_o  = flag_we_q;

  // R2: failed condition blocks both writes
  a_r2_fail_no_write: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cond_pass |=> (!result_we_o && !flags_we_o));

  // R2: failed condition passes flags through and holds result
  a_r2_fail_passthru: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cond_pass |=> (flags_o == $past(flags_i) && $stable(result_o)));

  // R1: code 1111 never executes
  a_r1_never: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cond_i == 4'hF) |=> (!result_we_o && !flags_we_o));

  // R4: tests set flags only
  a_r4_test_flags_only: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cond_pass && dec.known && dec.test_only) |=> (!result_we_o && flags_we_o));

  // R7: N and Z agree with a written result
  a_r7_nz_match: assert property (@(posedge clk) disable iff (!rst_n_s)
    (result_we_o && flags_we_o) |->
      (flags_o[FL_N] == result_o[W-1] && flags_o[FL_Z] == (result_o == '0)));

  // R9: bitwise forms keep V
  a_r9_logic_keeps_v: assert property (@(posedge clk) disable iff (!rst_n_s)
    (cond_pass && dec.cls == CLS_LOGIC) |=> (flags_o[FL_V] == $past(flags_i[FL_V])));

  // R11: unknown opcodes write nothing
  a_r11_unknown_op: assert property (@(posedge clk) disable iff (!rst_n_s)
    (op_i > 5'd16) |=> (!result_we_o && !flags_we_o));

endmodule

// File: tb/tb_cond_alu.sv
module tb_cond_alu;

  logic        clk;
  logic        rst_n;
  logic [4:0]  op;
  logic [3:0]  cond;
  logic        sflag;
  logic [31:0] a, b;
  logic [3:0]  fin;
  logic        scar;
  logic [31:0] res;
  logic        res_we;
  logic [3:0]  fout;
  logic        f_we;

  int total = 0;
  int bad   = 0;
  logic [31:0] exp_hold;
  bit done = 0;

  cond_alu dut (
    .clk(clk), .rst_n(rst_n), .op_i(op), .cond_i(cond), .set_flags_i(sflag),
    .op_a_i(a), .op_b_i(b), .flags_i(fin), .shift_carry_i(scar),
    .result_o(res), .result_we_o(res_we), .flags_o(fout), .flags_we_o(f_we)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic bit cond_ok(input logic [3:0] c, input logic [3:0] f);
    bit n, z, cy, v;
    n = f[3]; z = f[2]; cy = f[1]; v = f[0];
    case (c)
      4'd0:  return z;
      4'd1:  return !z;
      4'd2:  return cy;
      4'd3:  return !cy;
      4'd4:  return n;
      4'd5:  return !n;
      4'd6:  return v;
      4'd7:  return !v;
      4'd8:  return cy && !z;
      4'd9:  return !cy || z;
      4'd10: return n == v;
      4'd11: return n != v;
      4'd12: return !z && (n == v);
      4'd13: return z || (n != v);
      4'd14: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  task automatic model(input logic [4:0] o, input logic [3:0] c, input logic s,
                       input logic [31:0] x, input logic [31:0] y,
                       input logic [3:0] f, input logic sc,
                       output logic [31:0] val, output bit wr, output bit wf,
                       output logic [3:0] nf);
    longint ux, uy, sx, sy, u, sv;
    bit ar, sub, known, test, cy, ov;
    ux = longint'(x); uy = longint'(y);
    sx = longint'($signed(x)); sy = longint'($signed(y));
    ar = 0; sub = 0; known = 1; test = 0; u = 0; sv = 0; val = '0;
    case (o)
      5'd4, 5'd11: begin ar = 1; u = ux + uy; sv = sx + sy; end
      5'd5:  begin ar = 1; u = ux + uy + f[1]; sv = sx + sy + f[1]; end
      5'd2, 5'd10: begin ar = 1; sub = 1; u = ux - uy; sv = sx - sy; end
      5'd6:  begin ar = 1; sub = 1; u = ux - uy - (1 - f[1]); sv = sx - sy - (1 - f[1]); end
      5'd3:  begin ar = 1; sub = 1; u = uy - ux; sv = sy - sx; end
      5'd7:  begin ar = 1; sub = 1; u = uy - ux - (1 - f[1]); sv = sy - sx - (1 - f[1]); end
      5'd0, 5'd8:  val = x & y;
      5'd1, 5'd9:  val = x ^ y;
      5'd12: val = x | y;
      5'd16: val = x | ~y;
      5'd14: val = x & ~y;
      5'd13: val = y;
      5'd15: val = ~y;
      default: known = 0;
    endcase
    test = (o >= 5'd8 && o <= 5'd11);
    if (ar) val = u[31:0];
    if (ar) begin
      cy = sub ? (u >= 0) : (u > 64'sh0FFFF_FFFF);
      ov = (sv > 64'sh7FFF_FFFF) || (sv < -64'sh8000_0000);
    end else begin
      cy = sc;
      ov = f[0];
    end
    wr = cond_ok(c, f) && known && !test;
    wf = cond_ok(c, f) && known && (test || s);
    nf = wf ? {val[31], val == 32'd0, cy, ov} : f;
  endtask

  task automatic run_op(input logic [4:0] o, input logic [3:0] c, input logic s,
                        input logic [31:0] x, input logic [31:0] y,
                        input logic [3:0] f, input logic sc, input string tag);
    logic [31:0] val, er;
    bit wr, wf;
    logic [3:0] nf;
    op = o; cond = c; sflag = s; a = x; b = y; fin = f; scar = sc;
    model(o, c, s, x, y, f, sc, val, wr, wf, nf);
    if (wr) exp_hold = val;
    er = exp_hold;
    @(posedge clk);
    @(negedge clk);
    total++;
    if (res !== er || res_we !== wr || fout !== nf || f_we !== wf) begin
      bad++;
      $display("FAIL %s op=%0d cond=%0d: got res=%h we=%b fl=%b fwe=%b, exp res=%h we=%b fl=%b fwe=%b",
               tag, o, c, res, res_we, fout, f_we, er, wr, nf, wf);
    end
  endtask

  function automatic string tag_of(input logic [4:0] o, input logic [3:0] c,
                                   input logic [3:0] f);
    if (!cond_ok(c, f)) return (c == 4'hF) ? "R1" : "R2";
    if (o > 5'd16) return "R11";
    if (o >= 5'd8 && o <= 5'd11) return "R4";
    if (o >= 5'd2 && o <= 5'd7) return "R3/R8";
    return "R5/R9";
  endfunction

  initial begin
    rst_n = 1'b0; op = '0; cond = 4'hE; sflag = 0; a = '0; b = '0;
    fin = '0; scar = 0; exp_hold = '0;
    repeat (3) @(negedge clk);
    total++;
    if (res !== 32'd0 || res_we !== 1'b0 || fout !== 4'd0 || f_we !== 1'b0) begin
      bad++;
      $display("FAIL R10 reset: res=%h we=%b fl=%b fwe=%b exp all zero", res, res_we, fout, f_we);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // directed corners
    run_op(5'd4, 4'hE, 1, 32'h7FFF_FFFF, 32'd1, 4'b0000, 0, "R8 add overflow");
    run_op(5'd4, 4'hE, 1, 32'hFFFF_FFFF, 32'd1, 4'b0000, 0, "R7 add carry zero");
    run_op(5'd2, 4'hE, 1, 32'd5, 32'd5, 4'b0000, 0, "R8 sub equal");
    run_op(5'd2, 4'hE, 1, 32'd0, 32'd1, 4'b0000, 0, "R8 sub borrow");
    run_op(5'd6, 4'hE, 1, 32'd10, 32'd3, 4'b0000, 0, "R3 sbc c0");
    run_op(5'd7, 4'hE, 1, 32'd3, 32'd10, 4'b0010, 0, "R3 rsc c1");
    run_op(5'd3, 4'hE, 0, 32'd4, 32'd1, 4'b0101, 0, "R6 rsb no S");
    run_op(5'd13, 4'hE, 1, 32'h1234_5678, 32'hA5A5_0000, 4'b0001, 1, "R5 mov a1");
    run_op(5'd13, 4'hE, 1, 32'hFFFF_FFFF, 32'hA5A5_0000, 4'b0001, 1, "R5 mov a2");
    run_op(5'd15, 4'hE, 1, 32'h0, 32'hFFFF_FFFF, 4'b0000, 0, "R5 mvn zero");
    run_op(5'd16, 4'hE, 0, 32'h0000_00F0, 32'hFFFF_FF0F, 4'b0000, 0, "R5 orn");
    run_op(5'd14, 4'hE, 0, 32'hFFFF_FFFF, 32'h0000_FF00, 4'b0000, 0, "R5 bic");
    run_op(5'd10, 4'hE, 0, 32'd7, 32'd9, 4'b0000, 0, "R4 cmp no S");
    run_op(5'd8, 4'hE, 0, 32'h8000_0000, 32'h8000_0001, 4'b0001, 1, "R9 tst carry");
    run_op(5'd4, 4'hF, 1, 32'd1, 32'd1, 4'b1111, 0, "R1 never");
    run_op(5'd4, 4'h0, 1, 32'd9, 32'd9, 4'b1011, 1, "R2 eq fail");
    run_op(5'd20, 4'hE, 1, 32'd9, 32'd9, 4'b0110, 0, "R11 unknown");
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        run_op(5'd0, 4'(c), 1, 32'hFF, 32'h0F, 4'(f), 0, "R1 cond sweep");

    // random stream
    void'($urandom(32'd20240611));
    for (int i = 0; i < 3000; i++) begin
      logic [4:0]  ro;
      logic [3:0]  rc, rf;
      logic [31:0] ra, rb;
      ro = 5'($urandom_range(0, 19));
      rc = ($urandom_range(0, 3) == 0) ? 4'($urandom) : 4'hE;
      rf = 4'($urandom);
      ra = $urandom; rb = $urandom;
      if ($urandom_range(0, 7) == 0) rb = ra;
      if ($urandom_range(0, 7) == 0) ra = 32'h7FFF_FFFF;
      run_op(ro, rc, 1'($urandom), ra, rb, rf, 1'($urandom), tag_of(ro, rc, rf));
    end
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL R10 watchdog expired: got hung run, exp completion");
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule